// File: doc/BRIEF.md
# Byte-Lane Memory Access Adapter

This block joins a 16-bit datapath that works with byte addresses to a memory built from 16-bit words with a one-cycle synchronous read. It drops the lowest address bit to form the word address and steers bytes onto the correct lane of the memory data bus. A word access moves the full word. A byte access uses address bit 0 to choose the lane.

For a byte write, the low byte of the source register is placed on both lanes of the write bus. A two-bit lane-enable output marks the single lane that the memory must update. For a byte read, the chosen lane is returned as a 16-bit value, with the upper half filled from bit 7 of that byte. Word accesses must use even addresses. An odd word address sends no request to memory and produces a one-cycle error pulse instead.

Top module: `mem_lane_adapter`

## Requirements
- R1: For an accepted request, `mem_addr_o` equals `addr_i` shifted right by one, and `mem_req_o` is high in the same cycle. When `req_i` is low, `mem_req_o` is low.
- R2: A word write (`size_i`=0, `we_i`=1) at an even address drives `wdata_i` unchanged on `mem_wdata_o` with `mem_be_o`=2'b11.
- R3: A byte write (`size_i`=1) copies `wdata_i[7:0]` onto both halves of `mem_wdata_o`. `mem_be_o` is 2'b01 when `addr_i[0]`=0 and 2'b10 when `addr_i[0]`=1. Only that lane of the word changes.
- R4: A read sets `rvalid_o` high in the cycle after the request. A word read returns the full memory word on `rdata_o` in that cycle. Writes never set `rvalid_o`.
- R5: A byte read returns bits 7:0 of the memory word when `addr_i[0]`=0, and bits 15:8 when `addr_i[0]`=1, on `rdata_o[7:0]`.
- R6: On a byte read, `rdata_o[15:8]` are all copies of bit 7 of the selected byte.
- R7: A word access with `addr_i[0]`=1 does not raise `mem_req_o`, leaves memory unchanged, gives no `rvalid_o`, and raises `align_err_o` for exactly the following cycle.
- R8: Byte accesses at odd addresses never raise `align_err_o`.
- R9: While `rst_ni` is low, and after it is released, `rvalid_o` and `align_err_o` are low until a request arrives. `mem_be_o` is 2'b00 for every cycle without an issued write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 1 | 1 = byte, 0 = word |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 16 | Register value to store |
| rdata_o | output | 16 | Read result, valid with rvalid_o |
| rvalid_o | output | 1 | Read result strobe, one cycle after the request |
| align_err_o | output | 1 | Odd-address word access pulse |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 15 | Word address |
| mem_wdata_o | output | 16 | Lane-steered write data |
| mem_be_o | output | 2 | Lane write enables, bit 0 = low byte |
| mem_rdata_i | input | 16 | Memory word, one cycle after a read request |

## Verification
The assertions check the following relations on every cycle: a byte write enables exactly one lane, an odd word access never reaches memory, an error pulse never coincides with a read strobe, every strobe follows a read request, and byte results are sign-filled. The bench scenarios are needed for properties that depend on stored content. They show that a byte write leaves the other half of a word intact and that the lane picked by address bit 0 is the one returned. They also show that a rejected odd word write leaves memory unchanged, which can only be seen by reading the word back.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    ACC_WORD = 1'b0,
    ACC_BYTE = 1'b1
  } acc_size_e;
endpackage

// File: rtl/lane_req_gen.sv
module lane_req_gen
  import lane_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  localparam int unsigned NL = DW / BYTE_W,
  localparam int unsigned LW = $clog2(NL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  acc_size_e     size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-LW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [NL-1:0] mem_be_o,
  output logic          misalign_o,
  output logic [LW-1:0] lane_o
);
  logic issue;

  assign lane_o     = addr_i[LW-1:0];
  assign misalign_o = req_i && (size_i == ACC_WORD) && (lane_o != '0);
  assign issue      = req_i && !misalign_o;
  assign mem_req_o  = issue;
  assign mem_we_o   = issue && we_i;
  assign mem_addr_o = addr_i[AW-1:LW];

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign mem_wdata_o[g*BYTE_W +: BYTE_W] =
      (size_i == ACC_BYTE) ? wdata_i[BYTE_W-1:0] : wdata_i[g*BYTE_W +: BYTE_W];
    assign mem_be_o[g] = mem_we_o && ((size_i == ACC_WORD) || (lane_o == LW'(g)));
  end

  // R3: a byte write touches exactly one lane
  p_byte_one_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == ACC_BYTE) |-> ($countones(mem_be_o) == 1));

  // R7: odd word access never reaches memory
  p_misalign_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == ACC_WORD && addr_i[0]) |-> (!mem_req_o && mem_be_o == '0));

  // R9: no lane enabled without a write strobe
  p_be_needs_we_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_o |-> (mem_be_o == '0));
endmodule

// File: rtl/lane_rd_extract.sv
module lane_rd_extract
  import lane_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned NL = DW / BYTE_W,
  localparam int unsigned LW = $clog2(NL)
) (
  input  logic [DW-1:0] word_i,
  input  acc_size_e     size_i,
  input  logic [LW-1:0] lane_i,
  output logic [DW-1:0] data_o
);
  logic [BYTE_W-1:0] lane_b [NL];
  logic [BYTE_W-1:0] sel;

  for (genvar g = 0; g < NL; g++) begin : g_split
    assign lane_b[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  assign sel    = lane_b[lane_i];
  assign data_o = (size_i == ACC_BYTE) ? {{(DW-BYTE_W){sel[BYTE_W-1]}}, sel} : word_i;
endmodule

// File: rtl/mem_lane_adapter.sv
module mem_lane_adapter
  import lane_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  localparam int unsigned NL = DW / BYTE_W,
  localparam int unsigned LW = $clog2(NL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             size_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             align_err_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-LW-1:0] mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [NL-1:0]    mem_be_o,
  input  logic [DW-1:0]    mem_rdata_i
);
  acc_size_e size_e, size_q;
  logic [LW-1:0] lane, lane_q;
  logic misalign;
  logic rvalid_q, err_q;

  assign size_e = acc_size_e'(size_i);

  lane_req_gen #(.AW(AW), .DW(DW)) u_req (
    .clk_i, .rst_ni, .req_i, .we_i,
    .size_i     (size_e),
    .addr_i, .wdata_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_be_o,
    .misalign_o (misalign),
    .lane_o     (lane)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      size_q   <= ACC_WORD;
      lane_q   <= '0;
    end else begin
      rvalid_q <= req_i && !we_i && !misalign;
      err_q    <= misalign;
      if (req_i && !we_i) begin
        size_q <= size_e;
        lane_q <= lane;
      end
    end
  end

  lane_rd_extract #(.DW(DW)) u_rd (
    .word_i (mem_rdata_i),
    .size_i (size_q),
    .lane_i (lane_q),
    .data_o (rdata_o)
  );

  assign rvalid_o    = rvalid_q;
  assign align_err_o = err_q;

  // R4: strobe only after a read request
  p_rvalid_after_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  // R7: error pulse only after an odd word access, never with a strobe
  p_err_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> ($past(req_i && !size_i && addr_i[0]) && !rvalid_o));

  // R8: byte accesses never flag
  p_byte_no_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i) |=> !align_err_o);

  // R6: byte results are sign-filled
  p_sign_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(size_i)) |->
      (rdata_o[DW-1:BYTE_W] == {(DW-BYTE_W){rdata_o[BYTE_W-1]}}));
endmodule

// File: tb/mem_lane_adapter_tb.sv
module mem_lane_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, size = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata, mem_wdata, mem_rdata;
  logic        rvalid, align_err, mem_req, mem_we;
  logic [14:0] mem_addr;
  logic [1:0]  mem_be;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mem_lane_adapter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .align_err_o(align_err), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_rdata_i(mem_rdata)
  );

  // word memory model, synchronous read
  logic [15:0] mem [16];
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      if (mem_be[0]) mem[mem_addr[3:0]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr[3:0]][15:8] <= mem_wdata[15:8];
    end
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[3:0]];
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {we, size, addr, wdata, expected}
  localparam int NV = 14;
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h0000, 16'h1234, 16'h0000},
    {1'b0, 1'b0, 16'h0000, 16'h0000, 16'h1234},
    {1'b1, 1'b1, 16'h0001, 16'h00F0, 16'h0000},
    {1'b0, 1'b0, 16'h0000, 16'h0000, 16'hF034},
    {1'b0, 1'b1, 16'h0001, 16'h0000, 16'hFFF0},
    {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0034},
    {1'b1, 1'b1, 16'h0002, 16'hAA85, 16'h0000},
    {1'b0, 1'b0, 16'h0002, 16'h0000, 16'h0085},
    {1'b0, 1'b1, 16'h0002, 16'h0000, 16'hFF85},
    {1'b1, 1'b0, 16'h0004, 16'h7F80, 16'h0000},
    {1'b0, 1'b1, 16'h0005, 16'h0000, 16'h007F},
    {1'b0, 1'b1, 16'h0004, 16'h0000, 16'hFF80},
    {1'b1, 1'b1, 16'h0005, 16'h0001, 16'h0000},
    {1'b0, 1'b0, 16'h0004, 16'h0000, 16'h0180}
  };

  // drive one access, check request side, then result side after the edge
  task automatic access(input logic w, input logic s, input logic [15:0] a,
                        input logic [15:0] d, input logic [15:0] exp, input bit odd_word);
    @(negedge clk);
    req = 1'b1; we = w; size = s; addr = a; wdata = d;
    #1;
    if (odd_word) chk("R7 mem_req blocked", {15'd0, mem_req}, 16'd0);
    else chk("R1 word address", {1'b0, mem_addr}, {1'b0, a[15:1]});
    @(negedge clk);
    req = 1'b0;
    if (odd_word) begin
      chk("R7 align_err pulse", {15'd0, align_err}, 16'd1);
      chk("R7 no rvalid", {15'd0, rvalid}, 16'd0);
    end else begin
      chk(s ? "R8 no align_err on byte" : "R7 no align_err even", {15'd0, align_err}, 16'd0);
      chk(w ? "R4 no rvalid on write" : "R4 rvalid", {15'd0, rvalid}, {15'd0, !w});
      if (!w) chk(s ? "R5 R6 byte read" : "R4 word read", rdata, exp);
    end
  endtask

  initial begin
    #2;
    chk("R9 rvalid in reset", {15'd0, rvalid}, 16'd0);
    chk("R9 align_err in reset", {15'd0, align_err}, 16'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 rvalid after reset", {15'd0, rvalid}, 16'd0);
    chk("R1 idle mem_req", {15'd0, mem_req}, 16'd0);
    chk("R9 idle be", {14'd0, mem_be}, 16'd0);

    for (int i = 0; i < NV; i++)
      access(VEC[i][49], VEC[i][48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 1'b0);

    // R3: byte write lane steering, odd address
    @(negedge clk);
    req = 1'b1; we = 1'b1; size = 1'b1; addr = 16'h0009; wdata = 16'h125A;
    #1;
    chk("R3 byte wdata replicated", mem_wdata, 16'h5A5A);
    chk("R3 be high lane", {14'd0, mem_be}, 16'h0002);
    addr = 16'h0008;
    #1;
    chk("R3 be low lane", {14'd0, mem_be}, 16'h0001);
    addr = 16'h0009;
    // R2: word write enables both lanes, data untouched
    size = 1'b0; addr = 16'h0006; wdata = 16'hC3A5;
    #1;
    chk("R2 word be", {14'd0, mem_be}, 16'h0003);
    chk("R2 word wdata", mem_wdata, 16'hC3A5);
    we = 1'b0;
    #1;
    chk("R9 be zero on read", {14'd0, mem_be}, 16'h0000);
    req = 1'b0;

    // R7: odd word write rejected, memory unchanged
    access(1'b1, 1'b0, 16'h0003, 16'hFFFF, 16'h0000, 1'b1);
    @(negedge clk);
    chk("R7 pulse one cycle", {15'd0, align_err}, 16'd0);
    access(1'b0, 1'b0, 16'h0002, 16'h0000, 16'h0085, 1'b0);
    // R7: odd word read
    access(1'b0, 1'b0, 16'h0007, 16'h0000, 16'h0000, 1'b1);
    // R8: odd byte read, positive byte
    access(1'b0, 1'b1, 16'h0003, 16'h0000, 16'h0000, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule